// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block holds the two threshold offsets that a FIFO's almost-empty and almost-full comparators use. The almost-empty offset is a distance from the empty boundary. The almost-full offset is a distance from the full boundary. Both offsets sit in write-clock registers and drive the comparators directly.

Master reset sets the source of the offsets. A two-bit select picks one of three fixed presets (8, 16 or 64 words) or a user-programmed mode. In the user-programmed mode, a method pin is sampled at the same time. It chooses one of two ways to load values:
- Parallel loading writes the low bits of the write data bus, one offset per strobe.
- Serial loading shifts a single data bit in on each enabled clock edge.

Partial reset flushes the FIFO but leaves every setting of this block in place. While partial reset is high, all loading is frozen.

Top module: `flag_offset_loader`

## Requirements
- R1: On each clock edge where `masterRst` is high, both offsets are set from `presetSel`. The codes are 2'b00 = 8, 2'b01 = 16, 2'b10 = 64 and 2'b11 = 64. The new value is visible after that edge.
- R2: After a master reset with `presetSel` of 2'b00, 2'b01 or 2'b10, the offsets never change until the next master reset. This holds whatever `loadEn`, `serialEn`, `serialBit` or `wrData` do.
- R3: After a master reset with `presetSel` = 2'b11 (user-programmed), both offsets read 64 until the user loads new values.
- R4: With `serialMode` low at master reset (parallel method), each clock edge with `loadEn` high writes `wrData` into one offset. The first write goes to the almost-empty offset, the next to the almost-full offset, and then they alternate. The value is visible after that edge.
- R5: With `serialMode` high at master reset (serial method), each clock edge with `serialEn` high samples `serialBit`.
  - A load takes 2*OFFSET_W bits, sent most significant bit first.
  - The almost-empty bits come first, then the almost-full bits.
  - Both offsets update together on the edge that samples the last bit. Until then they hold their old values.
- R6: The loading method is fixed at master reset. In the serial method, `loadEn` has no effect. In the parallel method, `serialEn` has no effect.
- R7: While `partialRst` is high (and `masterRst` is low):
  - The offsets do not change.
  - Load strobes are ignored.
  - The parallel alternation and the count of serial bits already received are kept.
- R8: Master reset clears the loader state. After it, the next parallel write goes to the almost-empty offset, and any partly shifted serial sequence is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| masterRst | input | 1 | Synchronous master reset, active high |
| partialRst | input | 1 | Synchronous partial reset, active high; freezes the loader |
| presetSel | input | 2 | Preset select, sampled during master reset |
| serialMode | input | 1 | Method pin, sampled during master reset: 1 = serial, 0 = parallel |
| serialEn | input | 1 | Serial shift enable |
| serialBit | input | 1 | Serial data bit |
| loadEn | input | 1 | Parallel load strobe |
| wrData | input | OFFSET_W | Offset bits of the write data bus |
| aeOffset | output | OFFSET_W | Almost-empty offset to the flag comparator |
| afOffset | output | OFFSET_W | Almost-full offset to the flag comparator |

## Verification
The assertions check on every cycle that:
- partial reset and the preset modes leave both offsets unchanged;
- a strobe of the method not chosen never moves them;
- a parallel strobe changes at most one offset and flips the alternation;
- the serial bit count stays in range.

Only the bench scenarios can show the values themselves: which preset each code gives, the bit order of a serial load, and the return to the almost-empty offset after a new master reset. The bench compares these against a behavioural model on every clock.

// File: rtl/flagoff_pkg.sv
package flagoff_pkg;

  // Width that holds the largest preset value.
  localparam int PRESET_W = 7;

  typedef struct packed {
    logic applyPreset;  // master reset: load preset values
    logic loadAe;       // parallel write to almost-empty offset
    logic loadAf;       // parallel write to almost-full offset
    logic shiftEn;      // shift one serial bit into staging
    logic commitSerial; // last serial bit: move staging into offsets
  } ctrlStrobes_t;

  // Select codes: 00 -> 8, 01 -> 16, 10 -> 64, 11 -> user (default 64).
  function automatic logic [PRESET_W-1:0] presetValue(input logic [1:0] sel);
    case (sel)
      2'b00:   presetValue = 7'd8;
      2'b01:   presetValue = 7'd16;
      default: presetValue = 7'd64;
    endcase
  endfunction

endpackage

// File: rtl/flagoff_ctrl.sv
module flagoff_ctrl
  import flagoff_pkg::*;
#(
  parameter int OFFSET_W = 12
) (
  input  logic         clk,
  input  logic         masterRst,
  input  logic         partialRst,
  input  logic [1:0]   presetSel,
  input  logic         serialMode,
  input  logic         serialEn,
  input  logic         loadEn,
  output ctrlStrobes_t strobes,
  output logic         userMode,
  output logic         serialMethod
);

  localparam int SERIAL_BITS = 2 * OFFSET_W;
  localparam int CNT_W       = $clog2(SERIAL_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SERIAL_BITS - 1);

  logic             toggle;
  logic [CNT_W-1:0] bitCnt;
  logic             active;
  logic             parStrobe;

  assign active    = userMode && !partialRst && !masterRst;
  assign parStrobe = active && !serialMethod && loadEn;

  always_comb begin
    strobes              = '0;
    strobes.applyPreset  = masterRst;
    strobes.loadAe       = parStrobe && !toggle;
    strobes.loadAf       = parStrobe && toggle;
    strobes.shiftEn      = active && serialMethod && serialEn;
    strobes.commitSerial = strobes.shiftEn && (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk) begin
    if (masterRst) begin
      userMode     <= (presetSel == 2'b11);
      serialMethod <= serialMode;
      toggle       <= 1'b0;
      bitCnt       <= '0;
    end else begin
      if (parStrobe) toggle <= !toggle;
      if (strobes.shiftEn) begin
        if (bitCnt == LAST_BIT) bitCnt <= '0;
        else                    bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // R5: the serial bit counter never passes the last bit position
  assert_bitcnt_range_R5: assert property (@(posedge clk) disable iff (masterRst)
    bitCnt <= LAST_BIT);

  // R4: every accepted parallel write flips the alternation
  assert_toggle_flip_R4: assert property (@(posedge clk) disable iff (masterRst)
    (loadEn && userMode && !serialMethod && !partialRst) |=> (toggle != $past(toggle)));

  // R7: partial reset holds the alternation and the bit count
  assert_partial_keeps_state_R7: assert property (@(posedge clk) disable iff (masterRst)
    partialRst |=> ($stable(toggle) && $stable(bitCnt)));

endmodule

// File: rtl/flagoff_regs.sv
module flagoff_regs
  import flagoff_pkg::*;
#(
  parameter int OFFSET_W = 12
) (
  input  logic                clk,
  input  ctrlStrobes_t        strobes,
  input  logic [1:0]          presetSel,
  input  logic                serialBit,
  input  logic [OFFSET_W-1:0] wrData,
  output logic [OFFSET_W-1:0] aeOffset,
  output logic [OFFSET_W-1:0] afOffset
);

  localparam int SERIAL_BITS = 2 * OFFSET_W;

  logic [SERIAL_BITS-1:0] staging;
  logic [SERIAL_BITS-1:0] shiftNext;
  logic [OFFSET_W-1:0]    presetWide;

  assign shiftNext  = {staging[SERIAL_BITS-2:0], serialBit};
  assign presetWide = OFFSET_W'(presetValue(presetSel));

  always_ff @(posedge clk) begin
    if (strobes.applyPreset) begin
      aeOffset <= presetWide;
      afOffset <= presetWide;
      staging  <= '0;
    end else begin
      if (strobes.loadAe) aeOffset <= wrData;
      if (strobes.loadAf) afOffset <= wrData;
      if (strobes.shiftEn) staging <= shiftNext;
      if (strobes.commitSerial) begin
        aeOffset <= shiftNext[SERIAL_BITS-1:OFFSET_W];
        afOffset <= shiftNext[OFFSET_W-1:0];
      end
    end
  end

  // R4: a parallel write changes at most one of the two offsets
  assert_one_offset_per_load_R4: assert property (@(posedge clk) disable iff (strobes.applyPreset)
    (strobes.loadAe || strobes.loadAf) |=> ($stable(aeOffset) || $stable(afOffset)));

  // R5: shifting without the last bit leaves the offsets unchanged
  assert_serial_hold_R5: assert property (@(posedge clk) disable iff (strobes.applyPreset)
    (strobes.shiftEn && !strobes.commitSerial) |=> ($stable(aeOffset) && $stable(afOffset)));

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
  import flagoff_pkg::*;
#(
  parameter int OFFSET_W = 12
) (
  input  logic                clk,
  input  logic                masterRst,
  input  logic                partialRst,
  input  logic [1:0]          presetSel,
  input  logic                serialMode,
  input  logic                serialEn,
  input  logic                serialBit,
  input  logic                loadEn,
  input  logic [OFFSET_W-1:0] wrData,
  output logic [OFFSET_W-1:0] aeOffset,
  output logic [OFFSET_W-1:0] afOffset
);

  ctrlStrobes_t strobes;
  logic         userMode;
  logic         serialMethod;

  flagoff_ctrl #(.OFFSET_W(OFFSET_W)) uCtrl (
    .clk          (clk),
    .masterRst    (masterRst),
    .partialRst   (partialRst),
    .presetSel    (presetSel),
    .serialMode   (serialMode),
    .serialEn     (serialEn),
    .loadEn       (loadEn),
    .strobes      (strobes),
    .userMode     (userMode),
    .serialMethod (serialMethod)
  );

  flagoff_regs #(.OFFSET_W(OFFSET_W)) uRegs (
    .clk       (clk),
    .strobes   (strobes),
    .presetSel (presetSel),
    .serialBit (serialBit),
    .wrData    (wrData),
    .aeOffset  (aeOffset),
    .afOffset  (afOffset)
  );

  // R7: partial reset leaves both offsets untouched
  assert_partial_keeps_offsets_R7: assert property (@(posedge clk) disable iff (masterRst)
    partialRst |=> ($stable(aeOffset) && $stable(afOffset)));

  // R2: preset modes lock the offsets until the next master reset
  assert_preset_locked_R2: assert property (@(posedge clk) disable iff (masterRst)
    !userMode |=> ($stable(aeOffset) && $stable(afOffset)));

  // R6: a strobe of the unselected method never moves the offsets
  assert_method_fixed_R6: assert property (@(posedge clk) disable iff (masterRst)
    ((serialMethod ? !serialEn : !loadEn)) |=> ($stable(aeOffset) && $stable(afOffset)));

endmodule

// File: tb/tb_flag_offset_loader.sv
module tb_flag_offset_loader;

  localparam int W = 12;

  logic         clk = 1'b0;
  logic         masterRst = 1'b1;
  logic         partialRst = 1'b0;
  logic [1:0]   presetSel = 2'b00;
  logic         serialMode = 1'b0;
  logic         serialEn = 1'b0;
  logic         serialBit = 1'b0;
  logic         loadEn = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] aeOffset;
  logic [W-1:0] afOffset;

  always #2 clk = !clk;  // 250 MHz

  flag_offset_loader #(.OFFSET_W(W)) dut (
    .clk(clk), .masterRst(masterRst), .partialRst(partialRst),
    .presetSel(presetSel), .serialMode(serialMode), .serialEn(serialEn),
    .serialBit(serialBit), .loadEn(loadEn), .wrData(wrData),
    .aeOffset(aeOffset), .afOffset(afOffset)
  );

  // Behavioural reference model.
  int  refAe, refAf;
  bit  refUser, refSerial, refToggle, started;
  bit  bitQ[$];
  int  checks = 0, fails = 0, cycles = 0;
  string curReq = "R1";

  function automatic int presetOf(input logic [1:0] s);
    return (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 64;
  endfunction

  always @(posedge clk) begin
    started = 1'b1;
    if (masterRst) begin
      refUser   = (presetSel == 2'b11);
      refSerial = serialMode;
      refToggle = 1'b0;
      bitQ.delete();
      refAe = presetOf(presetSel);
      refAf = refAe;
    end else if (refUser && !partialRst) begin
      if (!refSerial && loadEn) begin
        if (!refToggle) refAe = int'(wrData);
        else            refAf = int'(wrData);
        refToggle = !refToggle;
      end
      if (refSerial && serialEn) begin
        bitQ.push_back(serialBit);
        if (bitQ.size() == 2 * W) begin
          refAe = 0; refAf = 0;
          for (int i = 0; i < W; i++) refAe = (refAe << 1) | int'(bitQ[i]);
          for (int i = W; i < 2 * W; i++) refAf = (refAf << 1) | int'(bitQ[i]);
          bitQ.delete();
        end
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (int'(aeOffset) != refAe || int'(afOffset) != refAf) begin
        fails++;
        $display("FAIL %s t=%0t ae=%0d af=%0d expected ae=%0d af=%0d",
                 curReq, $time, aeOffset, afOffset, refAe, refAf);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doMasterReset(input logic [1:0] sel, input logic ser);
    presetSel = sel; serialMode = ser; masterRst = 1'b1;
    idle(2);
    masterRst = 1'b0; presetSel = 2'b00; serialMode = !ser;
  endtask

  task automatic parLoad(input logic [W-1:0] v);
    wrData = v; loadEn = 1'b1; idle(1); loadEn = 1'b0;
  endtask

  task automatic shiftWord(input logic [2*W-1:0] v, input int nBits);
    for (int i = 2 * W - 1; i >= 2 * W - nBits; i--) begin
      serialBit = v[i]; serialEn = 1'b1; idle(1);
    end
    serialEn = 1'b0;
  endtask

  initial begin
    idle(1);
    // R1 and R2: each preset, then attempts to load that must be ignored
    for (int s = 0; s < 3; s++) begin
      curReq = "R1";
      doMasterReset(2'(s), 1'b0);
      idle(1);
      curReq = "R2";
      parLoad(12'h123); parLoad(12'h456);
      shiftWord(24'hABCDEF, 24);
      idle(2);
    end
    curReq = "R2";
    doMasterReset(2'b01, 1'b1);
    shiftWord(24'h135724, 24);
    idle(2);

    // R3: user mode defaults to 64
    curReq = "R3";
    doMasterReset(2'b11, 1'b0);
    idle(3);
    // R4: alternating parallel writes
    curReq = "R4";
    parLoad(12'h011); parLoad(12'h7F0); parLoad(12'hFFF); parLoad(12'h000);
    parLoad(12'h5A5);
    idle(1);
    // R6: serial enable ignored in parallel method
    curReq = "R6";
    shiftWord(24'hFFFFFF, 24);
    // R7: partial reset freezes loads and keeps alternation
    curReq = "R7";
    partialRst = 1'b1;
    parLoad(12'h999); parLoad(12'h888);
    partialRst = 1'b0;
    parLoad(12'h321);  // goes to almost-full (alternation kept)
    idle(1);
    // R8: new master reset restarts alternation at almost-empty
    curReq = "R8";
    doMasterReset(2'b11, 1'b0);
    parLoad(12'h0AB);
    idle(2);

    // R5: serial method
    curReq = "R5";
    doMasterReset(2'b11, 1'b1);
    shiftWord(24'hC35_00F, 24);
    idle(1);
    shiftWord(24'h800_001, 24);
    idle(1);
    // R6: parallel strobe ignored in serial method
    curReq = "R6";
    parLoad(12'h444); parLoad(12'h555);
    // R7: partial reset mid-sequence keeps the bit count
    curReq = "R7";
    shiftWord(24'h123_456, 10);
    partialRst = 1'b1;
    shiftWord(24'hFFF_FFF, 5);
    partialRst = 1'b0;
    shiftWord(24'h123_456 << 10, 14);
    idle(1);
    // R8: master reset discards a partial serial sequence
    curReq = "R8";
    shiftWord(24'hFFF_FFF, 9);
    doMasterReset(2'b11, 1'b1);
    shiftWord(24'h0F0_A0A, 24);
    idle(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule